// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block turns parallel 24-bit audio samples into a single serial data line. It frames them in one of four layouts: left-justified, I2S, right-justified, or a multi-slot TDM frame. Every slot is 32 bit clocks long. The stereo layouts use two slots per frame. TDM uses one slot per channel, and a one-bit-clock frame pulse marks slot 0. The output word length can be set to the full sample width or to 4, 6 or 8 bits fewer. Bits that fall outside the word inside a slot are driven to zero.

In master operation the block divides its system clock to make the bit clock and the frame clock. In slave operation it takes both clocks from outside. It brings them into its own clock domain and samples the frame clock on rising bit-clock edges. A frame-start edge realigns its bit counter. In both operations, data launches on falling bit-clock edges.

Samples for all channels of a frame arrive together on a parallel port. A ready/valid handshake guards a one-entry holding register. If no sample is waiting when a frame begins, the previous sample is sent again and an underrun flag is raised for that frame.

Top module: `audio_serial_tx`

## Requirements
- R1: In master operation `bclk_out` toggles every `HALF_DIV` clock cycles. `sdata` and `fclk_out` change only on the clock edge where `bclk_out` falls.
- R2: Data goes out MSB first. `cfg_wlen` selects the word length: 0 gives 24 bits, 1 gives 20, 2 gives 18 and 3 gives 16. The word is the top bits of the 24-bit sample. Slot bits outside the word are 0.
- R3: `cfg_fmt` codes are 0 left-justified, 1 I2S, 2 right-justified and 3 TDM. In codes 0 and 1 the frame clock is low during slot 0 (left) and high during slot 1. In code 2 it is high during slot 0 and low during slot 1. In code 3 it is high only during bit 0 of slot 0.
- R4: In left-justified and TDM framing the MSB is the first bit of its slot.
- R5: In I2S framing the MSB is the second bit of its slot, one bit clock after the frame clock edge.
- R6: In right-justified framing the MSB comes 32 minus the word length bit clocks into the slot, so the LSB is the last bit of the slot.
- R7: Channel c occupies `in_data[24c+23:24c]` and is sent in slot c. Stereo frames carry channels 0 and 1 (64 bit clocks). TDM frames carry all `SLOTS` channels (32·SLOTS bit clocks).
- R8: `in_ready` is low exactly while one accepted sample is waiting. A waiting sample becomes the frame word at the next frame start.
- R9: If no sample is waiting at a frame start, the previous frame word is repeated and `underrun` is 1 for that frame. A frame that starts with a new sample clears it.
- R10: In slave operation `bclk_in` and `fclk_in` drive the framing. The frame clock is sampled on rising bit-clock edges, and a frame-start edge realigns the bit counter to slot 0 bit 0. `sdata` is valid before the next rising `bclk_in`, and `bclk_out` and `fclk_out` stay low.
- R11: During reset `sdata`, `bclk_out`, `fclk_out` and `underrun` are 0 and `in_ready` is 1. The first falling bit clock after reset starts a frame at slot 0 bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1: generate bit and frame clocks; 0: take them from outside |
| cfg_fmt | input | 2 | Framing: 0 left-justified, 1 I2S, 2 right-justified, 3 TDM |
| cfg_wlen | input | 2 | Word length: 0→24, 1→20, 2→18, 3→16 bits |
| in_valid | input | 1 | A frame of samples is offered |
| in_ready | output | 1 | Holding register is free |
| in_data | input | SLOTS·24 | Samples, channel c in bits [24c+23:24c] |
| bclk_in | input | 1 | External bit clock (slave) |
| fclk_in | input | 1 | External frame clock (slave) |
| bclk_out | output | 1 | Generated bit clock (master) |
| fclk_out | output | 1 | Generated frame clock (master) |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | Current frame repeats the previous word |

## Verification
Some properties are checked by assertions on every cycle:
- the serial line and the generated frame clock move only with a falling generated bit clock;
- an accepted word always fills the holding register;
- an underrun can only start when no word was waiting;
- the master clock outputs are quiet in slave operation.

The bench scenarios show the rest:
- the slot placement of the MSB for each framing and word length;
- the frame clock level across each frame;
- the channel-to-slot order;
- the repetition of a stale word;
- realignment of the counter to an external frame clock.

// File: rtl/astx_pkg.sv
package astx_pkg;

   typedef enum logic [1:0] {
      FMT_LJ  = 2'd0,
      FMT_I2S = 2'd1,
      FMT_RJ  = 2'd2,
      FMT_TDM = 2'd3
   } fmt_e;

   // number of data bits kept from a sample of width full
   function automatic int word_bits(input logic [1:0] sel, input int full);
      case (sel)
         2'd0:    return full;
         2'd1:    return full - 4;
         2'd2:    return full - 6;
         default: return full - 8;
      endcase
   endfunction

endpackage

// File: rtl/astx_bitclk.sv
module astx_bitclk #(
   parameter int HALF_DIV    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic master,
   input  logic bclk_in,
   input  logic fclk_in,
   output logic bclk_out,
   output logic rise_evt,
   output logic fall_evt,
   output logic fclk_s
);
   localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   logic [DIV_W-1:0]       div_q;
   logic                   tick;
   logic [SYNC_STAGES-1:0] bsync;
   logic [SYNC_STAGES-1:0] fsync;
   logic                   b_last;

   assign tick = (div_q == DIV_W'(HALF_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q    <= '0;
         bclk_out <= 1'b0;
      end else if (!master) begin
         div_q    <= '0;
         bclk_out <= 1'b0;
      end else if (tick) begin
         div_q    <= '0;
         bclk_out <= ~bclk_out;
      end else begin
         div_q    <= div_q + 1'b1;
      end
   end

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bsync[0] <= 1'b0;
               fsync[0] <= 1'b0;
            end else begin
               bsync[0] <= bclk_in;
               fsync[0] <= fclk_in;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bsync[i] <= 1'b0;
               fsync[i] <= 1'b0;
            end else begin
               bsync[i] <= bsync[i-1];
               fsync[i] <= fsync[i-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) b_last <= 1'b0;
      else        b_last <= bsync[SYNC_STAGES-1];
   end

   assign fall_evt = master ? (tick & bclk_out)  : (b_last & ~bsync[SYNC_STAGES-1]);
   assign rise_evt = master ? (tick & ~bclk_out) : (~b_last & bsync[SYNC_STAGES-1]);
   assign fclk_s   = fsync[SYNC_STAGES-1];

endmodule

// File: rtl/astx_framer.sv
module astx_framer
   import astx_pkg::*;
#(
   parameter int SLOTS  = 4,
   parameter int SLOT_W = 32,
   localparam int FRAME_MAX = SLOTS * SLOT_W,
   localparam int POS_W     = $clog2(FRAME_MAX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             master,
   input  fmt_e             fmt,
   input  logic             rise_evt,
   input  logic             fall_evt,
   input  logic             fclk_s,
   output logic [POS_W-1:0] nxt_pos,
   output logic             wrap,
   output logic             fclk_out
);
   localparam int SW_W = $clog2(SLOT_W);
   localparam int CH_W = POS_W - SW_W;

   logic [POS_W-1:0] pos;
   logic [POS_W-1:0] last_pos;
   logic             at_end;
   logic             fs_prev;
   logic             start_edge;

   function automatic logic level_at(input fmt_e f, input logic [POS_W-1:0] p);
      logic [CH_W-1:0] slot;
      slot = p[POS_W-1:SW_W];
      case (f)
         FMT_TDM: return (p == '0);
         FMT_RJ:  return (slot == '0);
         default: return (slot == CH_W'(1));
      endcase
   endfunction

   assign last_pos   = (fmt == FMT_TDM) ? POS_W'(FRAME_MAX - 1) : POS_W'(2 * SLOT_W - 1);
   assign at_end     = (pos >= last_pos);
   assign wrap       = fall_evt & at_end;
   assign nxt_pos    = at_end ? '0 : pos + 1'b1;
   assign start_edge = (fmt == FMT_LJ || fmt == FMT_I2S) ? (fs_prev & ~fclk_s)
                                                         : (~fs_prev & fclk_s);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos      <= POS_W'(FRAME_MAX - 1);
         fclk_out <= 1'b0;
         fs_prev  <= 1'b0;
      end else begin
         if (!master) fclk_out <= 1'b0;
         if (fall_evt) begin
            pos <= nxt_pos;
            if (master) fclk_out <= level_at(fmt, nxt_pos);
         end else if (rise_evt && !master) begin
            fs_prev <= fclk_s;
            if (start_edge) pos <= '0;
         end
      end
   end

endmodule

// File: rtl/astx_sample_buf.sv
module astx_sample_buf #(
   parameter int SLOTS    = 4,
   parameter int SAMPLE_W = 24,
   localparam int WORD_W  = SLOTS * SAMPLE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   input  logic              wrap,
   output logic              in_ready,
   output logic [WORD_W-1:0] frame_word,
   output logic              underrun
);
   logic [WORD_W-1:0] pend_q;
   logic [WORD_W-1:0] cur_q;
   logic              pend_v;

   assign in_ready   = ~pend_v;
   assign frame_word = (wrap && pend_v) ? pend_q : cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= '0;
         cur_q    <= '0;
         pend_v   <= 1'b0;
         underrun <= 1'b0;
      end else begin
         if (wrap) begin
            if (pend_v) begin
               cur_q    <= pend_q;
               pend_v   <= 1'b0;
               underrun <= 1'b0;
            end else begin
               underrun <= 1'b1;
            end
         end
         if (in_valid && in_ready) begin
            pend_q <= in_data;
            pend_v <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/astx_serializer.sv
module astx_serializer
   import astx_pkg::*;
#(
   parameter int SLOTS    = 4,
   parameter int SLOT_W   = 32,
   parameter int SAMPLE_W = 24,
   localparam int POS_W   = $clog2(SLOTS * SLOT_W),
   localparam int WORD_W  = SLOTS * SAMPLE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fmt_e              fmt,
   input  logic [1:0]        wlen,
   input  logic              fall_evt,
   input  logic [POS_W-1:0]  nxt_pos,
   input  logic [WORD_W-1:0] frame_word,
   output logic              sdata
);
   localparam int SW_W  = $clog2(SLOT_W);
   localparam int IDX_W = $clog2(SAMPLE_W);

   logic [SAMPLE_W-1:0] ch_word [SLOTS];
   logic [SAMPLE_W-1:0] sel_word;
   logic [IDX_W-1:0]    bit_idx;
   logic                bit_v;
   int                  wl;
   int                  s_off;
   int                  k;

   for (genvar c = 0; c < SLOTS; c++) begin : g_unpack
      assign ch_word[c] = frame_word[c*SAMPLE_W +: SAMPLE_W];
   end

   always_comb begin
      wl = word_bits(wlen, SAMPLE_W);
      case (fmt)
         FMT_I2S: s_off = 1;
         FMT_RJ:  s_off = SLOT_W - wl;
         default: s_off = 0;
      endcase
      k        = int'(nxt_pos[SW_W-1:0]) - s_off;
      sel_word = ch_word[nxt_pos[POS_W-1:SW_W]];
      bit_idx  = IDX_W'(SAMPLE_W - 1 - k);
      bit_v    = 1'b0;
      if (k >= 0 && k < wl) bit_v = sel_word[bit_idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sdata <= 1'b0;
      else if (fall_evt) sdata <= bit_v;
   end

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
   import astx_pkg::*;
#(
   parameter int SLOTS       = 4,
   parameter int SLOT_W      = 32,
   parameter int SAMPLE_W    = 24,
   parameter int HALF_DIV    = 2,
   parameter int SYNC_STAGES = 2,
   localparam int WORD_W     = SLOTS * SAMPLE_W,
   localparam int POS_W      = $clog2(SLOTS * SLOT_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_master,
   input  logic [1:0]        cfg_fmt,
   input  logic [1:0]        cfg_wlen,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_data,
   input  logic              bclk_in,
   input  logic              fclk_in,
   output logic              bclk_out,
   output logic              fclk_out,
   output logic              sdata,
   output logic              underrun
);
   if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("SLOTS must be a power of two, at least 2");
   end
   if (SLOT_W < 2 || (SLOT_W & (SLOT_W - 1)) != 0) begin : g_bad_slot_w
      $error("SLOT_W must be a power of two");
   end
   if (SAMPLE_W < 16 || SAMPLE_W > SLOT_W) begin : g_bad_sample_w
      $error("SAMPLE_W must lie between 16 and SLOT_W");
   end
   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   fmt_e              fmt;
   logic              rise_evt;
   logic              fall_evt;
   logic              fclk_s;
   logic [POS_W-1:0]  nxt_pos;
   logic              wrap;
   logic [WORD_W-1:0] frame_word;

   assign fmt = fmt_e'(cfg_fmt);

   astx_bitclk #(.HALF_DIV(HALF_DIV), .SYNC_STAGES(SYNC_STAGES)) u_bitclk (
      .clk(clk), .rst_n(rst_n), .master(cfg_master),
      .bclk_in(bclk_in), .fclk_in(fclk_in), .bclk_out(bclk_out),
      .rise_evt(rise_evt), .fall_evt(fall_evt), .fclk_s(fclk_s)
   );

   astx_framer #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_framer (
      .clk(clk), .rst_n(rst_n), .master(cfg_master), .fmt(fmt),
      .rise_evt(rise_evt), .fall_evt(fall_evt), .fclk_s(fclk_s),
      .nxt_pos(nxt_pos), .wrap(wrap), .fclk_out(fclk_out)
   );

   astx_sample_buf #(.SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .wrap(wrap), .in_ready(in_ready), .frame_word(frame_word),
      .underrun(underrun)
   );

   astx_serializer #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .fmt(fmt), .wlen(cfg_wlen),
      .fall_evt(fall_evt), .nxt_pos(nxt_pos), .frame_word(frame_word),
      .sdata(sdata)
   );

endmodule

// File: rtl/audio_serial_tx_chk.sv
module audio_serial_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_master,
   input logic in_valid,
   input logic in_ready,
   input logic bclk_out,
   input logic fclk_out,
   input logic sdata,
   input logic underrun
);
   AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_master && !$stable(sdata)) |-> $fell(bclk_out)); // R1

   AST_FCLK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_master && !$stable(fclk_out)) |-> $fell(bclk_out)); // R3

   AST_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready); // R8

   AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(underrun) |-> $past(in_ready)); // R9

   AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_master && $past(!cfg_master)) |-> (!bclk_out && !fclk_out)); // R10

endmodule

bind audio_serial_tx audio_serial_tx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
   .in_valid(in_valid), .in_ready(in_ready), .bclk_out(bclk_out),
   .fclk_out(fclk_out), .sdata(sdata), .underrun(underrun)
);

// File: tb/audio_serial_tx_test.sv
module audio_serial_tx_test;
   localparam int SLOTS = 4;
   localparam int WW    = SLOTS * 24;
   localparam int HALF  = 2;
   localparam int SH    = 4;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          cfg_master = 1'b1;
   logic [1:0]    cfg_fmt = 2'd0;
   logic [1:0]    cfg_wlen = 2'd0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [WW-1:0] in_data = '0;
   logic          bclk_in = 1'b1;
   logic          fclk_in = 1'b0;
   logic          bclk_out, fclk_out, sdata, underrun;

   audio_serial_tx #(.SLOTS(SLOTS), .HALF_DIV(HALF)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_fmt(cfg_fmt),
      .cfg_wlen(cfg_wlen), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .bclk_in(bclk_in), .fclk_in(fclk_in),
      .bclk_out(bclk_out), .fclk_out(fclk_out), .sdata(sdata),
      .underrun(underrun)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_bit(input int fmt, input int wl,
                                  input logic [WW-1:0] w, input int pos);
      int slot, s, off, k;
      logic [WW-1:0] t;
      slot = pos / 32;
      s    = pos % 32;
      off  = (fmt == 1) ? 1 : (fmt == 2) ? 32 - wl : 0;
      k    = s - off;
      if (k < 0 || k >= wl) return 0;
      t = w >> (slot * 24 + 23 - k);
      return int'(t[0]);
   endfunction

   function automatic int exp_fclk(input int fmt, input int pos);
      if (fmt == 3) return (pos == 0) ? 1 : 0;
      if (fmt == 2) return (pos / 32 == 0) ? 1 : 0;
      return (pos / 32 == 1) ? 1 : 0;
   endfunction

   function automatic string fmt_tag(input int fmt);
      case (fmt)
         0: return "R2 R4";
         1: return "R2 R5";
         2: return "R2 R6";
         default: return "R2 R4 R7";
      endcase
   endfunction

   function automatic logic [WW-1:0] pattern(input int p);
      logic [WW-1:0] w;
      for (int c = 0; c < SLOTS; c++)
         w[c*24 +: 24] = 24'(p * 24'h1357B + c * 24'h2A5C3 + 24'h800001 + (p % 3) * 24'h7F0000);
      return w;
   endfunction

   // master model state
   bit            active_m = 0;
   int            fmt_i, wl_i, flen;
   int            bpos;
   bit            seen;
   int            frames;
   logic [WW-1:0] cur_w;
   logic [WW-1:0] q[$];
   bit            acc_prev;
   logic [WW-1:0] acc_data;
   int            feed_left;
   int            pat;
   logic          prev_b, prev_f, prev_d;
   int            half_cnt;
   bit            first_tog;
   bit            fell;
   int            eu;

   // slave model state
   bit            active_s = 0;
   int            s_hc, s_pos, s_frames;
   logic [WW-1:0] s_word;

   always @(negedge clk) begin
      if (active_m) begin
         fell = prev_b && !bclk_out;
         if (bclk_out != prev_b) begin
            if (!first_tog) chk(half_cnt == HALF, "R1", "bit clock half period", half_cnt, HALF);
            first_tog = 0;
            half_cnt  = 1;
         end else begin
            half_cnt++;
         end
         if (!fell) begin
            chk(sdata == prev_d, "R1", "sdata moved off a falling edge", int'(sdata), int'(prev_d));
            chk(fclk_out == prev_f, "R1", "fclk moved off a falling edge", int'(fclk_out), int'(prev_f));
         end else begin
            bpos = seen ? (bpos + 1) % flen : 0;
            seen = 1;
            if (bpos == 0) begin
               frames++;
               if (q.size() > 0) begin
                  cur_w = q.pop_front();
                  eu = 0;
               end else begin
                  eu = 1;
               end
            end
            chk(int'(underrun) == eu, "R9", "underrun flag", int'(underrun), eu);
            chk(int'(fclk_out) == exp_fclk(fmt_i, bpos), "R3", "frame clock level",
                int'(fclk_out), exp_fclk(fmt_i, bpos));
            chk(int'(sdata) == exp_bit(fmt_i, wl_i, cur_w, bpos), fmt_tag(fmt_i),
                $sformatf("data bit at pos %0d", bpos), int'(sdata), exp_bit(fmt_i, wl_i, cur_w, bpos));
         end
         if (acc_prev) q.push_back(acc_data);
         chk(in_ready == (q.size() == 0), "R8", "ready vs waiting word", int'(in_ready), int'(q.size() == 0));
         if (feed_left > 0 && in_ready) begin
            in_valid = 1'b1;
            in_data  = pattern(pat);
         end else begin
            in_valid = 1'b0;
         end
         acc_prev = in_valid && in_ready;
         acc_data = in_data;
         if (acc_prev) begin
            feed_left--;
            pat++;
         end
         prev_b = bclk_out;
         prev_f = fclk_out;
         prev_d = sdata;
      end
      if (active_s) begin
         chk(!bclk_out && !fclk_out, "R10", "master clocks quiet in slave",
             int'({bclk_out, fclk_out}), 0);
         s_hc++;
         if (s_hc == SH) begin
            s_hc    = 0;
            bclk_in = ~bclk_in;
            if (!bclk_in) begin
               s_pos = (s_pos + 1) % flen;
               if (s_pos == 0) s_frames++;
               fclk_in = exp_fclk(fmt_i, s_pos) != 0;
            end else if (s_frames >= 2) begin
               chk(int'(sdata) == exp_bit(fmt_i, wl_i, s_word, s_pos),
                   {"R10 ", fmt_tag(fmt_i)}, $sformatf("slave data bit at pos %0d", s_pos),
                   int'(sdata), exp_bit(fmt_i, wl_i, s_word, s_pos));
               chk(underrun == 1'b1, "R9", "slave repeat flags underrun", int'(underrun), 1);
            end
         end
      end
   end

   task automatic do_reset(input bit master, input int fmt, input int wlen);
      rst_n      = 1'b0;
      cfg_master = master;
      cfg_fmt    = 2'(fmt);
      cfg_wlen   = 2'(wlen);
      in_valid   = 1'b0;
      fmt_i      = fmt;
      wl_i       = (wlen == 0) ? 24 : (wlen == 1) ? 20 : (wlen == 2) ? 18 : 16;
      flen       = (fmt == 3) ? SLOTS * 32 : 64;
      bclk_in    = 1'b1;
      fclk_in    = exp_fclk(fmt, flen - 1) != 0;
      repeat (3) @(negedge clk);
      chk(!sdata && !bclk_out && !fclk_out && !underrun && in_ready, "R11",
          "reset state", int'({sdata, bclk_out, fclk_out, underrun, in_ready}), 1);
   endtask

   task automatic run_master(input int fmt, input int wlen, input int nfeed, input int nframes);
      do_reset(1'b1, fmt, wlen);
      bpos = 0; seen = 0; frames = 0; cur_w = '0; q.delete();
      acc_prev = 0; feed_left = nfeed;
      prev_b = 0; prev_f = 0; prev_d = 0; half_cnt = 0; first_tog = 1;
      @(negedge clk);
      rst_n    = 1'b1;
      active_m = 1;
      while (frames <= nframes) @(negedge clk);
      active_m = 0;
      in_valid = 1'b0;
   endtask

   task automatic run_slave(input int fmt, input int wlen, input int nframes);
      do_reset(1'b0, fmt, wlen);
      s_word = pattern(pat);
      pat++;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = s_word;
      @(negedge clk);
      in_valid = 1'b0;
      chk(!in_ready, "R8", "word waits in holding register", int'(in_ready), 0);
      s_hc = 0; s_pos = -1; s_frames = 0;
      active_s = 1;
      while (s_frames <= nframes) @(negedge clk);
      active_s = 0;
   endtask

   initial begin
      pat = 1;
      run_master(0, 0, 2, 4);   // left-justified, 24 bit, then stale words (R9)
      run_master(1, 1, 10, 3);  // I2S, 20 bit
      run_master(2, 2, 10, 3);  // right-justified, 18 bit
      run_master(2, 3, 10, 3);  // right-justified, 16 bit
      run_master(3, 0, 10, 3);  // TDM, 24 bit (R7)
      run_master(3, 3, 10, 2);  // TDM, 16 bit
      run_slave(0, 0, 4);       // R10 slave left-justified
      run_slave(1, 1, 4);
      run_slave(2, 3, 4);
      run_slave(3, 0, 3);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule